// File: doc/BRIEF.md
# Serial Command and Display-Data Port

This block is the host-facing serial port of a display controller. A host selects the port with a chip-select line, clocks bits in on a data line, and frames each transfer as 64 clocks. The bits accumulate in a shift register. When chip select drops, a 4-bit opcode embedded in the frame decides what happens to the rest of the frame. It can be written to a 60-bit display latch, loaded as an 11-bit digital dimming word, used to switch between analog and digital dimming, used to stop the key scanner, or used to arm a key read-back.

Once a read-back is armed, the next chip-select window turns the data line around. The port captures the 30 key bits from the key scanner when that window opens, then presents them one bit per rising serial clock, starting with key row 0 column 0. When that window closes the port goes back to accepting display input. The contents of the read window are never decoded. All pins are sampled in the system clock domain and edges are detected there, and every output comes from a register.

Top module: `disp_cmd_port`

## Requirements
- R1: The shift register takes the data bit on each rising serial clock seen while chip select is high. Serial clocks with chip select low are ignored. A frame shorter than 64 clocks combines with the bits already held.
- R2: Opcode 0000 loads the display latch on the falling edge of chip select. Counting frame positions from 64 for the first bit in, positions 64..53 become display bits 59..48 and positions 48..1 become display bits 47..0. The opcode sits in positions 52..49, with bit 3 of the opcode at position 52.
- R3: The display latch, dimming word and dimming select change only in the clock cycle after a falling edge of chip select.
- R4: Opcode 0001 loads the dimming word from positions 63..53, MSB at 63. Position 64 is ignored. The same opcode also selects digital dimming.
- R5: The dimming select flag (1 = digital) is set by 0101, 0100 and 0001. It is cleared by 0011 and 0010. Opcodes 0010 and 0100 also load the display latch.
- R6: Opcodes 0111, 0110 and 1000 arm a read-back (0110 also loads the display latch). In the next chip-select window the data output carries key bit 0 (row 0, column 0) first. Each rising serial clock advances one key index in row-major order of six columns per row. After key 29 the output is 0.
- R7: The falling chip select that ends a read window returns the port to display input and decodes nothing from that window.
- R8: Opcodes 1000 and 1001 pulse the scan stop output for one cycle after the falling edge of chip select.
- R9: Opcodes outside the ten listed (for example 1010 and 1111) change no output.
- R10: After reset the display latch and dimming word are zero, analog dimming is selected, no read-back is armed, and all strobes are low.
- R11: The scan read output pulses for one cycle when a read window opens, in the same cycle that the key bits are captured.
- R12: The output enable is high only while chip select is high in an armed read window. The data output is 0 whenever the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock |
| sdio_i | input | 1 | Serial data in |
| keys_i | input | 30 | Key state, index row*6+column |
| disp_o | output | 60 | Display latch |
| dim_word_o | output | 11 | Digital dimming word |
| dim_digital_o | output | 1 | 1 = digital dimming selected |
| scan_stop_o | output | 1 | One-cycle key scan stop strobe |
| scan_read_o | output | 1 | One-cycle read window start strobe |
| sdio_o | output | 1 | Serial data out |
| sdio_oe_o | output | 1 | Drive enable for the data pin |

## Verification
The hidden state is the 64-bit shift register and the armed-read flag. A corrupted shift-register bit stays invisible until the next chip-select fall. At that point it appears either as a wrong display or dimming bit or as a misdecoded opcode, so each frame's outcome is compared at the cycle after the fall. A wrong armed-read flag shows up one cycle after chip select rises, as a wrong output enable or a missing read strobe. The bench therefore compares every output on every clock against a queue-based model and adds targeted checks at frame ends.

// File: rtl/disp_cmd_pkg.sv
package disp_cmd_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_DISP       = 4'b0000,
    OP_DIM_LOAD   = 4'b0001,
    OP_DISP_ANA   = 4'b0010,
    OP_ANA        = 4'b0011,
    OP_DISP_DIG   = 4'b0100,
    OP_DIG        = 4'b0101,
    OP_DISP_READ  = 4'b0110,
    OP_READ       = 4'b0111,
    OP_READ_STOP  = 4'b1000,
    OP_STOP       = 4'b1001
  } opcode_e;

  typedef struct packed {
    logic load_disp;
    logic load_dim;
    logic sel_dig;
    logic sel_ana;
    logic arm_read;
    logic stop;
  } action_t;
endpackage

// File: rtl/disp_cmd_edge.sv
module disp_cmd_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst) q_r <= '0;
    else     q_r <= sig_i;
  end

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_edge
      assign rise_o[gi] = sig_i[gi] & ~q_r[gi];
      assign fall_o[gi] = ~sig_i[gi] & q_r[gi];
    end
  endgenerate

  assign q_o = q_r;
endmodule

// File: rtl/disp_cmd_shreg.sv
module disp_cmd_shreg #(
  parameter int FRAME_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_i,
  input  logic               bit_i,
  output logic [FRAME_W-1:0] data_o
);
  logic [FRAME_W-1:0] sh_r;

  always_ff @(posedge clk) begin
    if (rst)       sh_r <= '0;
    else if (en_i) sh_r <= {sh_r[FRAME_W-2:0], bit_i};
  end

  assign data_o = sh_r;

  assert_noshift_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(data_o));
endmodule

// File: rtl/disp_cmd_decode.sv
module disp_cmd_decode
  import disp_cmd_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output action_t         act_o
);
  always_comb begin
    act_o = '0;
    case (op_i)
      OP_DISP:      act_o.load_disp = 1'b1;
      OP_DIM_LOAD:  begin act_o.load_dim = 1'b1; act_o.sel_dig = 1'b1; end
      OP_DISP_ANA:  begin act_o.load_disp = 1'b1; act_o.sel_ana = 1'b1; end
      OP_ANA:       act_o.sel_ana = 1'b1;
      OP_DISP_DIG:  begin act_o.load_disp = 1'b1; act_o.sel_dig = 1'b1; end
      OP_DIG:       act_o.sel_dig = 1'b1;
      OP_DISP_READ: begin act_o.load_disp = 1'b1; act_o.arm_read = 1'b1; end
      OP_READ:      act_o.arm_read = 1'b1;
      OP_READ_STOP: begin act_o.arm_read = 1'b1; act_o.stop = 1'b1; end
      OP_STOP:      act_o.stop = 1'b1;
      default:      act_o = '0;
    endcase
  end

  always_comb begin
    assert_dimsel_excl_R5: assert ($onehot0({act_o.sel_dig, act_o.sel_ana}));
  end
endmodule

// File: rtl/disp_cmd_readout.sv
module disp_cmd_readout #(
  parameter int KEY_W = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [KEY_W-1:0] keys_i,
  output logic             bit_o
);
  logic [KEY_W-1:0] rd_r;

  always_ff @(posedge clk) begin
    if (rst)          rd_r <= '0;
    else if (load_i)  rd_r <= keys_i;
    else if (shift_i) rd_r <= {1'b0, rd_r[KEY_W-1:1]};
  end

  assign bit_o = rd_r[0];
endmodule

// File: rtl/disp_cmd_port.sv
module disp_cmd_port
  import disp_cmd_pkg::*;
#(
  parameter int FRAME_W = 64,
  parameter int DISP_W  = 60,
  parameter int OP_LSB  = 48,
  parameter int DIM_W   = 11,
  parameter int KEY_W   = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_i,
  input  logic              sclk_i,
  input  logic              sdio_i,
  input  logic [KEY_W-1:0]  keys_i,
  output logic [DISP_W-1:0] disp_o,
  output logic [DIM_W-1:0]  dim_word_o,
  output logic              dim_digital_o,
  output logic              scan_stop_o,
  output logic              scan_read_o,
  output logic              sdio_o,
  output logic              sdio_oe_o
);
  localparam int LO_W    = OP_LSB;
  localparam int HI_W    = DISP_W - LO_W;
  localparam int DIM_LSB = OP_LSB + OP_W;
  localparam int IDX_CS  = 1;
  localparam int IDX_SC  = 0;

  logic [1:0] pin_q, pin_rise, pin_fall;
  logic       cs_q, cs_rise, cs_fall, sclk_rise;
  logic [FRAME_W-1:0] sh;
  action_t    act;
  logic       read_armed_r;
  logic       rd_bit;
  logic       shift_en, rd_load, rd_shift;

  disp_cmd_edge #(.W(2)) u_edge (
    .clk(clk), .rst(rst), .sig_i({cs_i, sclk_i}),
    .q_o(pin_q), .rise_o(pin_rise), .fall_o(pin_fall)
  );

  assign cs_q      = pin_q[IDX_CS];
  assign cs_rise   = pin_rise[IDX_CS];
  assign cs_fall   = pin_fall[IDX_CS];
  assign sclk_rise = pin_rise[IDX_SC];
  assign shift_en  = sclk_rise & cs_i;

  disp_cmd_shreg #(.FRAME_W(FRAME_W)) u_shreg (
    .clk(clk), .rst(rst), .en_i(shift_en), .bit_i(sdio_i), .data_o(sh)
  );

  disp_cmd_decode u_dec (
    .op_i(sh[OP_LSB +: OP_W]), .act_o(act)
  );

  assign rd_load  = cs_rise & read_armed_r;
  assign rd_shift = shift_en & read_armed_r;

  disp_cmd_readout #(.KEY_W(KEY_W)) u_rd (
    .clk(clk), .rst(rst), .load_i(rd_load), .shift_i(rd_shift),
    .keys_i(keys_i), .bit_o(rd_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_o        <= '0;
      dim_word_o    <= '0;
      dim_digital_o <= 1'b0;
      read_armed_r  <= 1'b0;
      scan_stop_o   <= 1'b0;
      scan_read_o   <= 1'b0;
    end else begin
      scan_stop_o <= cs_fall & ~read_armed_r & act.stop;
      scan_read_o <= rd_load;
      if (cs_fall) begin
        if (read_armed_r) begin
          read_armed_r <= 1'b0;
        end else begin
          if (act.arm_read)  read_armed_r  <= 1'b1;
          if (act.load_disp) disp_o        <= {sh[FRAME_W-1 -: HI_W], sh[LO_W-1:0]};
          if (act.load_dim)  dim_word_o    <= sh[DIM_LSB +: DIM_W];
          if (act.sel_dig)   dim_digital_o <= 1'b1;
          if (act.sel_ana)   dim_digital_o <= 1'b0;
        end
      end
    end
  end

  assign sdio_oe_o = cs_q & read_armed_r;
  assign sdio_o    = sdio_oe_o & rd_bit;

  assert_disp_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !(cs_q && !cs_i) |=> ($stable(disp_o) && $stable(dim_digital_o)));
  assert_oe_needs_cs_R12: assert property (@(posedge clk) disable iff (rst)
    sdio_oe_o |-> $past(cs_i));
  assert_stop_single_R8: assert property (@(posedge clk) disable iff (rst)
    scan_stop_o |=> !scan_stop_o);
  assert_dimword_digital_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(dim_word_o) |-> dim_digital_o);
  assert_read_strobe_oe_R11: assert property (@(posedge clk) disable iff (rst)
    scan_read_o |-> sdio_oe_o);
endmodule

// File: tb/disp_cmd_port_test.sv
module disp_cmd_port_test;
  localparam int PERIOD = 10;
  localparam int KW = 30;

  logic clk = 0, rst = 1, cs = 0, sclk = 0, sdi = 0;
  logic [KW-1:0] keys = '0;
  logic [59:0] disp;
  logic [10:0] dimw;
  logic dig, stop, rdp, sdo, oe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  disp_cmd_port uut (
    .clk(clk), .rst(rst), .cs_i(cs), .sclk_i(sclk), .sdio_i(sdi), .keys_i(keys),
    .disp_o(disp), .dim_word_o(dimw), .dim_digital_o(dig), .scan_stop_o(stop),
    .scan_read_o(rdp), .sdio_o(sdo), .sdio_oe_o(oe)
  );

  // behavioural model
  logic q[$];
  logic [59:0] m_disp;
  logic [10:0] m_dimw;
  logic m_dig, m_stop, m_rdp, m_rd, m_csq, m_scq, m_oe, m_sdo;
  logic [KW-1:0] m_keys;
  int idx;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      q = {};
      for (int i = 0; i < 64; i++) q.push_back(1'b0);
      m_disp = '0; m_dimw = '0; m_dig = 0; m_stop = 0; m_rdp = 0;
      m_rd = 0; m_csq = 0; m_scq = 0; m_keys = '0; idx = KW;
    end else begin
      logic rs, cr, cf;
      logic [3:0] op;
      rs = sclk & !m_scq; cr = cs & !m_csq; cf = !cs & m_csq;
      m_stop = 0; m_rdp = 0;
      if (cf) begin
        if (m_rd) m_rd = 0;
        else begin
          op = {q[12], q[13], q[14], q[15]};
          if (op inside {4'b0000, 4'b0010, 4'b0100, 4'b0110})
            for (int k = 0; k < 60; k++) m_disp[k] = (k >= 48) ? q[59-k] : q[63-k];
          if (op == 4'b0001)
            for (int j = 0; j < 11; j++) m_dimw[j] = q[11-j];
          if (op inside {4'b0001, 4'b0101, 4'b0100}) m_dig = 1;
          if (op inside {4'b0011, 4'b0010}) m_dig = 0;
          if (op inside {4'b0111, 4'b0110, 4'b1000}) m_rd = 1;
          if (op inside {4'b1000, 4'b1001}) m_stop = 1;
        end
      end
      if (cr && m_rd) begin m_keys = keys; idx = 0; m_rdp = 1; end
      if (rs && cs) begin
        q.push_back(sdi); void'(q.pop_front());
        if (m_rd) idx++;
      end
      m_csq = cs; m_scq = sclk;
    end
    m_oe = m_csq & m_rd;
    m_sdo = (m_oe && idx < KW) ? m_keys[idx] : 1'b0;
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 disp", 64'(disp), 64'(m_disp));
      chk("R4 dimw", 64'(dimw), 64'(m_dimw));
      chk("R5 dig", 64'(dig), 64'(m_dig));
      chk("R8 stop", 64'(stop), 64'(m_stop));
      chk("R11 rd", 64'(rdp), 64'(m_rdp));
      chk("R12 oe", 64'(oe), 64'(m_oe));
      chk("R6 sdo", 64'(sdo), 64'(m_sdo));
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #(PERIOD/4);
  endtask

  task automatic send(logic [63:0] v, int n);
    logic [59:0] d0;
    d0 = disp;
    cs = 1; step(2);
    for (int i = 0; i < n; i++) begin
      sdi = v[63-i]; sclk = 0; step(2);
      sclk = 1; step(2);
      if (i == 32) chk("R3 disp held mid-frame", 64'(disp), 64'(d0));
    end
    sclk = 0; step(2);
    cs = 0; step(3);
  endtask

  function automatic logic [63:0] dframe(logic [59:0] d, logic [3:0] op);
    return {d[59:48], op, d[47:0]};
  endfunction

  task automatic stray(int n);
    for (int i = 0; i < n; i++) begin
      sdi = 1; sclk = 1; step(2); sclk = 0; step(2);
    end
  endtask

  initial begin
    step(3); rst = 0; step(1);
    chk("R10 disp", 64'(disp), 0); chk("R10 dimw", 64'(dimw), 0);
    chk("R10 dig", 64'(dig), 0); chk("R10 oe", 64'(oe), 0);
    chk("R10 stop", 64'(stop), 0);
    send(dframe(60'hABC_1234_5678_9DEF, 4'b0000), 64);
    chk("R2 display load", 64'(disp), 64'h0ABC_1234_5678_9DEF);
    send({1'b1, 11'h5A3, 4'b0001, 48'hFFFF_0000_FFFF}, 64);
    chk("R4 dim word", 64'(dimw), 64'h5A3); chk("R5 digital", 64'(dig), 1);
    send(dframe(60'h0, 4'b0011), 64); chk("R5 analog", 64'(dig), 0);
    send(dframe(60'h0, 4'b0101), 64); chk("R5 digital sel", 64'(dig), 1);
    send(dframe(60'h111_2222_3333_4444, 4'b0010), 64); chk("R5 disp+ana", 64'(dig), 0);
    send(dframe(60'h555_6666_7777_8888, 4'b0100), 64); chk("R5 disp+dig", 64'(dig), 1);
    send(dframe(60'hFFF_FFFF_FFFF_FFFF, 4'b1010), 64);
    chk("R9 nop 1010", 64'(disp), 64'h0555_6666_7777_8888);
    send({1'b0, 11'h7FF, 4'b1111, 48'h0}, 64);
    chk("R9 nop 1111", 64'(dimw), 64'h5A3);
    keys = 30'h2A5C_3E19;
    send(dframe(60'h0, 4'b0111), 64);
    send(64'hDEAD_BEEF_0000_0000, 30);
    chk("R7 read not decoded", 64'(disp), 64'h0555_6666_7777_8888);
    chk("R7 oe low after", 64'(oe), 0);
    send(dframe(60'h0A0_0B0B_0C0C_0D0D, 4'b0000), 64);
    chk("R7 back to display", 64'(disp), 64'h00A0_0B0B_0C0C_0D0D);
    keys = 30'h1555_5555;
    send(dframe(60'h123_4567_89AB_CDEF, 4'b0110), 64);
    send(dframe(60'hEEE_EEEE_EEEE_EEEE, 4'b0000), 64);
    chk("R7 read frame ignored", 64'(disp), 64'h0123_4567_89AB_CDEF);
    keys = 30'h3FFF_0001;
    send(dframe(60'h0, 4'b1000), 64);
    send(64'h0, 34);
    send(dframe(60'h0, 4'b1001), 64);
    stray(8);
    send(64'hC3C3_5A5A_0F0F_9696, 56);
    chk("R1 oe idle", 64'(oe), 0);
    step(4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule